// File: doc/BRIEF.md
# Two-Channel Conditional Search Qualifier

This block decides whether a device should answer a conditional search. It watches two general-purpose input channels. Each pin is synchronised, then filtered so that only a level that holds for a minimum number of clocks counts as a change. An accepted change in either direction sets that channel's sticky activity latch. A clear pulse empties the latches.

A small register set picks the channels that take part through a mask. It also gives each channel a required polarity and chooses whether the compared signals are the latches or the filtered live levels. A combine-type bit reduces the per-channel results by OR (any selected channel matches) or by AND (every selected channel matches). The result drives the response flag, which follows the registers and latches with no extra register stage. Registers are reached through a plain address, write-data and write-strobe port, with a combinational read path.

Each channel filter is a three-state machine. `FLT_INIT` waits for the synchroniser to fill and then adopts the pin level without reporting activity (transition INIT→STABLE). `FLT_STABLE` holds the accepted level and moves to `FLT_QUALIFY` as soon as the synchronised pin differs from it (STABLE→QUALIFY). `FLT_QUALIFY` counts consecutive differing samples. If the pin returns to the old level it goes back with no change (QUALIFY→STABLE, rejected). Once `FILT_CYC` consecutive differing samples are seen it accepts the new level and pulses the change strobe (QUALIFY→STABLE, accepted).

Top module: `csq_top`

## Requirements
- R1: After reset the latch status register (0x0221), the mask register (0x0222) and the control register (0x0223) read 00h, and resp_o is 0.
- R2: A pin transition, low-to-high or high-to-low, whose new level holds for FILT_CYC consecutive synchronised samples sets that channel's latch. Channel n is reported in bit n of 0x0221.
- R3: A pin pulse shorter than FILT_CYC clocks leaves the latches unchanged.
- R4: A latch bit stays 1 through later pin changes until clr_latch_i is high at a clock edge, which clears all latch bits to 0.
- R5: When a transition is accepted in the same cycle as clr_latch_i, that channel's latch ends up set.
- R6: The mask register at 0x0222 stores bits [1:0] (bit n selects channel n); bits [7:2] read 0 even after writing FFh.
- R7: The control register at 0x0223 holds bits [1:0] as polarity for channels 0 and 1, bit 2 as source select (1 = latches, 0 = filtered pins) and bit 3 as combine type (1 = AND, 0 = OR); bits [7:4] read 0.
- R8: In OR mode resp_o is 1 exactly when at least one selected channel's signal equals its polarity bit.
- R9: In AND mode resp_o is 1 exactly when every selected channel's signal equals its polarity bit. With no channel selected, resp_o is 1 in AND mode and 0 in OR mode.
- R10: With source select 1 the comparison uses the latch bits rather than the pin levels.
- R11: Reads of any address other than 0x0221–0x0223 return 00h. Writes to 0x0221 or to an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Asynchronous channel pins |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Write strobe |
| clr_latch_i | input | 1 | Clear all activity latches |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| resp_o | output | 1 | Conditional search response flag |

## Verification
The bench builds the block with FILT_CYC = 4 and the default two channels. The short window makes the accepted-edge cycle easy to predict, so a clear pulse can be placed exactly on the acceptance edge to prove that the set wins. It also keeps a two-clock glitch well below the threshold. With both channels, mixed polarities and empty masks reach every OR/AND corner, and an activity latch can be made to disagree with its live pin.

// File: rtl/csq_pkg.sv
package csq_pkg;
    typedef enum logic [1:0] {
        FLT_INIT    = 2'd0,
        FLT_STABLE  = 2'd1,
        FLT_QUALIFY = 2'd2
    } flt_state_e;

    localparam int REG_W    = 8;
    localparam int SYNC_LAT = 2;
endpackage

// File: rtl/csq_pin_filter.sv
module csq_pin_filter
    import csq_pkg::*;
#(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic change_o
);
    localparam int RAW_W = $clog2(FILT_CYC + 1);
    localparam int CNT_W = (RAW_W < 2) ? 2 : RAW_W;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILT_CYC - 1);
    localparam logic [CNT_W-1:0] INIT_LIM = CNT_W'(SYNC_LAT);

    logic       meta_q, sync_q;
    flt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic       level_q, level_d;
    logic       change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_INIT;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        change  = 1'b0;
        unique case (state_q)
            FLT_INIT: begin
                if (cnt_q == INIT_LIM) begin
                    level_d = sync_q;
                    cnt_d   = '0;
                    state_d = FLT_STABLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FLT_STABLE: begin
                if (sync_q != level_q) begin
                    cnt_d   = CNT_W'(1);
                    state_d = FLT_QUALIFY;
                end
            end
            FLT_QUALIFY: begin
                if (sync_q == level_q) begin
                    cnt_d   = '0;
                    state_d = FLT_STABLE;
                end else if (cnt_q == LIMIT) begin
                    level_d = sync_q;
                    change  = 1'b1;
                    cnt_d   = '0;
                    state_d = FLT_STABLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = FLT_INIT;
        endcase
    end

    assign level_o  = level_q;
    assign change_o = change;

    AST_STABLE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_STABLE) |=> $stable(level_q)); // R3
endmodule

// File: rtl/csq_resp_logic.sv
module csq_resp_logic #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] sig_i,
    input  logic [NUM_CH-1:0] pol_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic              all_i,
    output logic              resp_o
);
    logic [NUM_CH-1:0] match;
    logic [NUM_CH-1:0] and_in;
    logic [NUM_CH-1:0] or_in;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            assign match[g]  = (sig_i[g] == pol_i[g]);
            assign and_in[g] = match[g] | ~mask_i[g];
            assign or_in[g]  = match[g] & mask_i[g];
        end
    endgenerate

    assign resp_o = all_i ? (&and_in) : (|or_in);
endmodule

// File: rtl/csq_top.sv
module csq_top
    import csq_pkg::*;
#(
    parameter int              NUM_CH     = 2,
    parameter int              FILT_CYC   = 8,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h0221,
    parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0222,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h0223
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic              reg_we_i,
    input  logic              clr_latch_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              resp_o
);
    localparam int SRC_BIT  = NUM_CH;
    localparam int COMB_BIT = NUM_CH + 1;
    localparam int CTRL_W   = NUM_CH + 2;

    logic [NUM_CH-1:0] level, change, latch_q;
    logic [NUM_CH-1:0] mask_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_CH-1:0] sig;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            csq_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_i    (pin_i[g]),
                .level_o  (level[g]),
                .change_o (change[g])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              latch_q[g] <= 1'b0;
                else if (change[g])      latch_q[g] <= 1'b1;
                else if (clr_latch_i)    latch_q[g] <= 1'b0;
            end

            AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (latch_q[g] && !clr_latch_i) |=> latch_q[g]); // R4
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (change[g] && clr_latch_i) |=> latch_q[g]); // R5
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (reg_we_i) begin
            if (reg_addr_i == MASK_ADDR) mask_q <= reg_wdata_i[NUM_CH-1:0];
            if (reg_addr_i == CTRL_ADDR) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == LATCH_ADDR)     reg_rdata_o[NUM_CH-1:0] = latch_q;
        else if (reg_addr_i == MASK_ADDR) reg_rdata_o[NUM_CH-1:0] = mask_q;
        else if (reg_addr_i == CTRL_ADDR) reg_rdata_o[CTRL_W-1:0] = ctrl_q;
    end

    assign sig = ctrl_q[SRC_BIT] ? latch_q : level;

    csq_resp_logic #(.NUM_CH(NUM_CH)) u_resp (
        .sig_i  (sig),
        .pol_i  (ctrl_q[NUM_CH-1:0]),
        .mask_i (mask_q),
        .all_i  (ctrl_q[COMB_BIT]),
        .resp_o (resp_o)
    );

    AST_MASK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == MASK_ADDR) |-> (reg_rdata_o[REG_W-1:NUM_CH] == '0)); // R6
    AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == CTRL_ADDR) |-> (reg_rdata_o[REG_W-1:CTRL_W] == '0)); // R7
    AST_EMPTY_AND_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[COMB_BIT] && mask_q == '0) |-> resp_o); // R9
    AST_EMPTY_OR_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[COMB_BIT] && mask_q == '0) |-> !resp_o); // R9
endmodule

// File: tb/csq_top_bench.sv
module csq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 4;
    localparam int SETTLE     = FILT + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin = 2'b00;
    logic [15:0] addr = 16'h0000;
    logic [7:0] wdata = 8'h00;
    logic       we = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] rdata;
    logic       resp;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    csq_top #(.NUM_CH(2), .FILT_CYC(FILT)) u_csq_top (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_we_i(we), .clr_latch_i(clr),
        .reg_rdata_o(rdata), .resp_o(resp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic resp_chk(input string tag, input logic exp);
        @(negedge clk); #1;
        chk(tag, {7'd0, resp}, {7'd0, exp});
    endtask

    task automatic drive_pin(input int ch, input logic v);
        @(negedge clk); pin[ch] = v;
        repeat (SETTLE) @(posedge clk);
    endtask

    task automatic clear_latches();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 latch reg", 16'h0221, 8'h00);
        rd_chk("R1 mask reg", 16'h0222, 8'h00);
        rd_chk("R1 ctrl reg", 16'h0223, 8'h00);
        resp_chk("R1 resp", 1'b0);
    endtask

    task automatic t_regs();
        wr(16'h0222, 8'hFF);
        rd_chk("R6 mask upper zero", 16'h0222, 8'h03);
        wr(16'h0223, 8'hFF);
        rd_chk("R7 ctrl upper zero", 16'h0223, 8'h0F);
        wr(16'h0221, 8'hFF);
        rd_chk("R11 latch reg not writable", 16'h0221, 8'h00);
        rd_chk("R11 unmapped read", 16'h0100, 8'h00);
        wr(16'h0224, 8'h00);
        wr(16'h0000, 8'h00);
        rd_chk("R11 mask kept", 16'h0222, 8'h03);
        rd_chk("R11 ctrl kept", 16'h0223, 8'h0F);
        wr(16'h0222, 8'h00);
        wr(16'h0223, 8'h00);
    endtask

    task automatic t_glitch();
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); pin[0] = 1'b0;
        repeat (SETTLE) @(posedge clk);
        rd_chk("R3 short pulse ignored", 16'h0221, 8'h00);
    endtask

    task automatic t_latch();
        drive_pin(1, 1'b1);
        rd_chk("R2 rising edge ch1", 16'h0221, 8'h02);
        drive_pin(1, 1'b0);
        rd_chk("R4 latch sticky", 16'h0221, 8'h02);
        clear_latches();
        rd_chk("R4 clear", 16'h0221, 8'h00);
        drive_pin(0, 1'b1);
        rd_chk("R2 rising edge ch0", 16'h0221, 8'h01);
        clear_latches();
        drive_pin(0, 1'b0);
        rd_chk("R2 falling edge ch0", 16'h0221, 8'h01);
        clear_latches();
    endtask

    task automatic t_set_wins();
        @(negedge clk); pin[0] = 1'b1;
        repeat (FILT + 1) @(posedge clk);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        rd_chk("R5 set beats clear", 16'h0221, 8'h01);
        drive_pin(0, 1'b0);
        clear_latches();
        rd_chk("R5 cleanup", 16'h0221, 8'h00);
    endtask

    task automatic t_or_mode();
        wr(16'h0222, 8'h03);
        wr(16'h0223, 8'h00);
        resp_chk("R8 OR both match", 1'b1);
        wr(16'h0223, 8'h03);
        resp_chk("R8 OR none match", 1'b0);
        drive_pin(1, 1'b1);
        resp_chk("R8 OR one match", 1'b1);
        wr(16'h0222, 8'h01);
        resp_chk("R8 OR unselected match ignored", 1'b0);
        wr(16'h0222, 8'h00);
        resp_chk("R9 OR empty mask", 1'b0);
    endtask

    task automatic t_and_mode();
        wr(16'h0222, 8'h03);
        wr(16'h0223, 8'h0A);
        resp_chk("R9 AND all match", 1'b1);
        wr(16'h0223, 8'h0B);
        resp_chk("R9 AND one mismatch", 1'b0);
        wr(16'h0222, 8'h02);
        resp_chk("R9 AND mismatch unselected", 1'b1);
        wr(16'h0222, 8'h00);
        resp_chk("R9 AND empty mask", 1'b1);
    endtask

    task automatic t_latch_src();
        clear_latches();
        wr(16'h0222, 8'h03);
        wr(16'h0223, 8'h07);
        resp_chk("R10 latches clear, live pin ignored", 1'b0);
        drive_pin(0, 1'b1);
        resp_chk("R10 latch set", 1'b1);
        clear_latches();
        resp_chk("R10 latch cleared, pin high", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (6) @(posedge clk);
        t_reset();
        t_regs();
        t_glitch();
        t_latch();
        t_set_wins();
        t_or_mode();
        t_and_mode();
        t_latch_src();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule